// File: doc/BRIEF.md
# Bit-Serial Ranked Minimum Selector

This block takes a batch of K distance values and returns the addresses of the M smallest, one address at a time, in ascending order of distance. It does not sort with comparators. It runs a bit-serial elimination: in each round every candidate still in the race offers one bit of its distance per cycle, from the most significant bit down.

Each candidate keeps a contender flag. A candidate that has dropped out is masked so that it always offers a 1. A single AND across all offered bits gives the smallest bit value at the current position, and any contender that offered a larger bit loses its flag. When the least significant bit has been processed, the lowest-addressed remaining contender is the winner. It is then inhibited for the rest of the batch, and the next round starts.

Distances are 22-bit two's-complement values by default. Their sign bit is inverted on entry, so that the unsigned MSB-first race orders them by signed value.

A batch enters through a valid/ready load port. The load is accepted on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is high only while the block is idle. Results leave through a valid/ready port. Once `win_valid` rises, it and `win_addr` hold until a cycle with `win_ready` high, and the next round starts only after that handshake. `done` is a plain level flag.

Top module: `topm_serial_finder`

## Requirements
- R1: After reset, `in_ready` is 1, `win_valid` is 0 and `done` is 0.
- R2: A batch is accepted only on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the batch completes. Values on `in_valid` and `in_dist` while `in_ready` is 0 have no effect on the results.
- R3: Candidate i takes its distance from `in_dist[i*22 +: 22]`, a two's-complement value. Results appear in ascending signed order of distance, covering the full range from -2097152 to 2097151.
- R4: Among equal distances, the lower address is reported first. No address is reported twice within one batch.
- R5: A batch produces exactly min(M, K) results, where M is `in_count`, and then raises `done`. When M is 0, `done` rises with no result.
- R6: While `win_valid` is 1 and `win_ready` is 0, `win_valid` stays 1 and `win_addr` stays unchanged on the next cycle.
- R7: `done` stays 1 until the next batch is accepted, and it is 0 from the cycle after that acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Batch offered on the load port |
| in_ready | output | 1 | Block idle and able to accept a batch |
| in_dist | input | K*DIST_W (2200) | All K distances; candidate i in bits i*DIST_W upward |
| in_count | input | CNT_W (8) | Number M of ranked results requested |
| win_valid | output | 1 | A winner address is presented |
| win_ready | input | 1 | Consumer takes the presented address |
| win_addr | output | IDX_W (7) | Address of the current round's winner |
| done | output | 1 | Last requested result has been taken, or M was 0 |

## Verification
The hardest situation to reach from the ports is a batch with many exact ties that is still running after most candidates have been inhibited. There the masking of inhibited candidates and the lowest-address choice among several surviving flags must interact correctly. The stimulus creates it in two ways. One batch has all distances equal and asks for more results than there are candidates, which forces every address out in index order. Another batch mixes duplicated values with the most negative and most positive 22-bit codes and runs under a held-off consumer. Throughout these runs, offers on the load port during a busy batch show that it stays closed.

// File: rtl/topm_pkg.sv
package topm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_INIT,
    ST_RACE,
    ST_SHOW
  } race_state_t;
endpackage

// File: rtl/topm_ctrl.sv
module topm_ctrl
  import topm_pkg::*;
#(
  parameter int K     = 100,
  parameter int W     = 22,
  parameter int CNT_W = 8,
  parameter int BIT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] in_count,
  input  logic             win_ready,
  output logic             in_ready,
  output logic             load_fire,
  output logic             round_init,
  output logic             racing,
  output logic             showing,
  output logic [BIT_W-1:0] bit_idx,
  output logic             done
);
  localparam logic [CNT_W-1:0] K_CNT   = CNT_W'(K);
  localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(W - 1);

  race_state_t      st;
  logic [CNT_W-1:0] found;
  logic [CNT_W-1:0] limit;

  assign in_ready   = (st == ST_IDLE);
  assign load_fire  = in_ready && in_valid;
  assign round_init = (st == ST_INIT);
  assign racing     = (st == ST_RACE);
  assign showing    = (st == ST_SHOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      found   <= '0;
      limit   <= '0;
      bit_idx <= '0;
      done    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (in_valid) begin
          limit <= (in_count > K_CNT) ? K_CNT : in_count;
          found <= '0;
          done  <= 1'b0;
          st    <= ST_INIT;
        end
        ST_INIT: if (found == limit) begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end else begin
          bit_idx <= TOP_BIT;
          st      <= ST_RACE;
        end
        ST_RACE: if (bit_idx == '0) st <= ST_SHOW;
                 else bit_idx <= bit_idx - 1'b1;
        ST_SHOW: if (win_ready) begin
          found <= found + 1'b1;
          st    <= ST_INIT;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5
  found_within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found <= limit);
  // R7
  done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load_fire |=> done);
  // R2
  busy_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> !in_ready && !done);
endmodule

// File: rtl/topm_cell.sv
module topm_cell #(
  parameter int W           = 22,
  parameter int BIT_W       = 5,
  parameter bit SIGNED_DIST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     dist_in,
  input  logic             round_init,
  input  logic             racing,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             min_bit,
  input  logic             take_me,
  output logic             offer_bit,
  output logic             contender
);
  logic [W-1:0] ordered;
  logic [W-1:0] key;
  logic         inhibit;

  generate
    if (SIGNED_DIST) begin : g_signed
      assign ordered = {~dist_in[W-1], dist_in[W-2:0]};
    end else begin : g_unsigned
      assign ordered = dist_in;
    end
  endgenerate

  assign offer_bit = key[bit_idx] | ~contender;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key       <= '0;
      inhibit   <= 1'b0;
      contender <= 1'b0;
    end else if (load) begin
      key       <= ordered;
      inhibit   <= 1'b0;
      contender <= 1'b0;
    end else if (round_init) begin
      contender <= ~inhibit;
    end else if (racing) begin
      contender <= contender & ~(offer_bit & ~min_bit);
    end else if (take_me) begin
      inhibit   <= 1'b1;
      contender <= 1'b0;
    end
  end

  // R4
  inhibited_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |-> !contender);
  // R4
  inhibit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit && !load |=> inhibit);
endmodule

// File: rtl/topm_pick.sv
module topm_pick #(
  parameter int K     = 100,
  parameter int IDX_W = 7
) (
  input  logic [K-1:0]     flags,
  output logic [IDX_W-1:0] sel,
  output logic             any
);
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = K - 1; i >= 0; i--) begin
      if (flags[i]) begin
        sel = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/topm_serial_finder.sv
module topm_serial_finder
  import topm_pkg::*;
#(
  parameter int K           = 100,
  parameter int DIST_W      = 22,
  parameter bit SIGNED_DIST = 1'b1,
  parameter int CNT_W       = $clog2(K + 1) + 1,
  parameter int IDX_W       = (K > 1) ? $clog2(K) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [K*DIST_W-1:0]   in_dist,
  input  logic [CNT_W-1:0]      in_count,
  output logic                  win_valid,
  input  logic                  win_ready,
  output logic [IDX_W-1:0]      win_addr,
  output logic                  done
);
  localparam int BIT_W = (DIST_W > 1) ? $clog2(DIST_W) : 1;

  logic             load_fire, round_init, racing, showing;
  logic [BIT_W-1:0] bit_idx;
  logic [K-1:0]     offers;
  logic [K-1:0]     flags;
  logic             min_bit;
  logic             any_flag;
  logic             take;

  topm_ctrl #(.K(K), .W(DIST_W), .CNT_W(CNT_W), .BIT_W(BIT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_count(in_count),
    .win_ready(win_ready), .in_ready(in_ready), .load_fire(load_fire),
    .round_init(round_init), .racing(racing), .showing(showing),
    .bit_idx(bit_idx), .done(done)
  );

  assign min_bit = &offers;
  assign take    = showing && win_ready;

  generate
    for (genvar i = 0; i < K; i++) begin : g_cell
      topm_cell #(.W(DIST_W), .BIT_W(BIT_W), .SIGNED_DIST(SIGNED_DIST)) u_cell (
        .clk(clk), .rst_n(rst_n), .load(load_fire),
        .dist_in(in_dist[i*DIST_W +: DIST_W]),
        .round_init(round_init), .racing(racing), .bit_idx(bit_idx),
        .min_bit(min_bit), .take_me(take && (win_addr == IDX_W'(i))),
        .offer_bit(offers[i]), .contender(flags[i])
      );
    end
  endgenerate

  topm_pick #(.K(K), .IDX_W(IDX_W)) u_pick (
    .flags(flags), .sel(win_addr), .any(any_flag)
  );

  assign win_valid = showing;

  // R3
  winner_exists_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> any_flag);
  // R3
  flags_only_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    racing |=> (flags & ~$past(flags)) == '0);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && !win_ready |=> win_valid && $stable(win_addr));
endmodule

// File: tb/test_topm_serial_finder.sv
module test_topm_serial_finder;
  localparam int K = 100;
  localparam int W = 22;
  localparam int CNT_W = $clog2(K + 1) + 1;
  localparam int IDX_W = $clog2(K);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [K*W-1:0] in_dist = '0;
  logic [CNT_W-1:0] in_count = '0;
  logic win_valid;
  logic win_ready = 1'b0;
  logic [IDX_W-1:0] win_addr;
  logic done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic signed [W-1:0] d [K];
  int exp_addr [K];

  always #4 clk = ~clk;

  topm_serial_finder i_topm_serial_finder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dist(in_dist), .in_count(in_count), .win_valid(win_valid),
    .win_ready(win_ready), .win_addr(win_addr), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  function automatic int build_expected(input int m);
    bit taken [K];
    int n = (m > K) ? K : m;
    for (int i = 0; i < K; i++) taken[i] = 1'b0;
    for (int r = 0; r < n; r++) begin
      int best = -1;
      for (int i = 0; i < K; i++)
        if (!taken[i] && (best < 0 || d[i] < d[best])) best = i;
      taken[best] = 1'b1;
      exp_addr[r] = best;
    end
    return n;
  endfunction

  task automatic run_batch(input int m, input int stall, input bit poke,
                           input string req);
    int n;
    int got = 0;
    int guard = 0;
    logic [K*W-1:0] flat;
    n = build_expected(m);
    for (int i = 0; i < K; i++) flat[i*W +: W] = d[i];
    @(negedge clk);
    check(in_ready == 1'b1, "R2", "in_ready before load", in_ready, 1);
    in_dist = flat;
    in_count = CNT_W'(m);
    in_valid = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R2", "in_ready after accept", in_ready, 0);
    check(done == 1'b0, "R7", "done cleared by load", done, 0);
    if (poke) begin
      in_dist = ~flat;
      in_count = CNT_W'(1);
    end else begin
      in_valid = 1'b0;
    end
    while (guard < 20000) begin
      if (done) break;
      if (win_valid) begin
        logic [IDX_W-1:0] held = win_addr;
        if (got < n)
          check(int'(win_addr) == exp_addr[got], req, "ranked address",
                int'(win_addr), exp_addr[got]);
        else
          check(1'b0, "R5", "extra result", got + 1, n);
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          guard++;
          check(win_valid == 1'b1 && win_addr == held, "R6", "held under stall",
                int'(win_addr), int'(held));
        end
        win_ready = 1'b1;
        @(negedge clk);
        win_ready = 1'b0;
        got++;
      end else begin
        @(negedge clk);
        guard++;
      end
    end
    in_valid = 1'b0;
    in_dist = flat;
    check(guard < 20000, "R5", "batch finished", guard, 20000);
    check(got == n, "R5", "result count", got, n);
    repeat (3) @(negedge clk);
    check(done == 1'b1 && in_ready == 1'b1, "R7", "done persists", done, 1);
    check(win_valid == 1'b0, "R5", "no result after done", win_valid, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready at reset", in_ready, 1);
    check(win_valid == 1'b0, "R1", "win_valid at reset", win_valid, 0);
    check(done == 1'b0, "R1", "done at reset", done, 0);
  endtask

  task automatic t_mixed_signs();
    for (int i = 0; i < K; i++) d[i] = W'(((i * 7919 + 131) % 4000000) - 2000000);
    d[37] = W'(-2097152);
    d[64] = W'(2097151);
    d[5]  = W'(-1);
    d[6]  = W'(0);
    run_batch(12, 0, 1'b1, "R3");
  endtask

  task automatic t_ties();
    for (int i = 0; i < K; i++) d[i] = W'(500);
    run_batch(200, 0, 1'b0, "R4");
  endtask

  task automatic t_dup_stall();
    for (int i = 0; i < K; i++) d[i] = W'((i % 4) * 1000 - 1500);
    d[90] = W'(2097151);
    d[3]  = W'(-2097152);
    run_batch(6, 3, 1'b0, "R4");
  endtask

  task automatic t_zero_count();
    for (int i = 0; i < K; i++) d[i] = W'(K - i);
    run_batch(0, 0, 1'b0, "R5");
  endtask

  task automatic t_reverse_full();
    for (int i = 0; i < K; i++) d[i] = W'((K - i) * 20000 - 1000000);
    run_batch(K, 0, 1'b0, "R3");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mixed_signs();
    t_ties();
    t_dup_stall();
    t_zero_count();
    t_reverse_full();
    finish_run();
  end
endmodule